// File: doc/BRIEF.md
# Registered Command/Address Buffer with Delayed Parity Check

This block is a single-clock register stage for the command and address bus of a memory module. On every rising clock edge it captures the address/command bits and the control lines. The control lines are the clock enables, the on-die termination enables and the active-low chip selects. The captured address/command, clock-enable and termination values are re-driven as two identical copies, an A side and a B side, so that each copy drives half of the module's memory devices.

The block also guards the address/command bits with even/odd parity. The expected parity bit for a command does not arrive with the command: it comes on the parity input one clock later. The block computes the parity of the captured address/command bits and compares it with that late bit. It does this only for cycles in which a chip select was active. A mismatch pulls the active-low error output low for a fixed number of cycles. The control lines never take part in the parity computation.

A static strap selects between two modes:
- Dual chip-select mode: two chip-select inputs, each copied to an A-side and a B-side output.
- Quad chip-select mode: four chip-select inputs, each with its own dedicated output.

Top module: `ca_regbuf`

## Requirements
- R1: Each of `ac_a`, `cke_a`, `odt_a` equals the value that `ac_in`, `cke_in`, `odt_in` had at the previous rising edge (one register of latency).
- R2: The B-side outputs `ac_b`, `cke_b`, `odt_b` always equal their A-side counterparts.
- R3: With `quad_cs_n` = 1 (dual mode), bits 0 and 2 of `cs_out_n` both carry the registered `cs_in_n[0]`, and bits 1 and 3 both carry the registered `cs_in_n[1]`. `cs_in_n[3:2]` have no effect on any output.
- R4: With `quad_cs_n` = 0 (quad mode), `cs_out_n[i]` carries the registered `cs_in_n[i]` for i = 0..3.
- R5: The computed parity of a command is the XOR of all `AC_W` bits of `ac_in`, which is the LSB of their sum. It is compared with `par_in` sampled at the following rising edge. On a mismatch, `err_n` is 0 starting right after that edge.
- R6: `cke_in`, `odt_in` and `cs_in_n` do not enter the parity computation. Toggling them while `par_in` holds the address-only parity raises no error.
- R7: A command is checked only when it was selected, meaning at least one enabled chip select was 0. In dual mode only `cs_in_n[1:0]` are enabled; in quad mode all four are enabled. An unselected command with wrong parity leaves `err_n` at 1.
- R8: A detected mismatch holds `err_n` at 0 for exactly `ERR_HOLD` (default 2) cycles. A new mismatch inside that window restarts the count.
- R9: A synchronous active-high `rst` sets every `cs_out_n` bit to 1, sets the clock-enable, termination and address outputs to 0, sets `err_n` to 1 and discards the pending parity check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| quad_cs_n | input | 1 | Strap: 0 selects quad chip-select mode, 1 selects dual mode |
| ac_in | input | AC_W | Address/command bits |
| cke_in | input | 2 | Clock enables |
| odt_in | input | 2 | On-die termination enables |
| cs_in_n | input | 4 | Active-low chip selects |
| par_in | input | 1 | Parity of the previous cycle's address/command |
| ac_a | output | AC_W | Registered address/command, A side |
| ac_b | output | AC_W | Registered address/command, B side |
| cke_a | output | 2 | Registered clock enables, A side |
| cke_b | output | 2 | Registered clock enables, B side |
| odt_a | output | 2 | Registered termination enables, A side |
| odt_b | output | 2 | Registered termination enables, B side |
| cs_out_n | output | 4 | Registered chip selects, routed per strap |
| err_n | output | 1 | Active-low parity error, stretched for ERR_HOLD cycles |

## Verification
The bench builds the block with its defaults: `AC_W` = 22 and `ERR_HOLD` = 2. The two-cycle hold is short enough that random traffic with a one-in-eight parity corruption often lands a second mismatch inside an open error window, which exercises the restart of the count. A directed sequence then walks the exact low window cycle by cycle. The random phases are run under both strap settings, so the chip-select routing and the rule for which chip selects count as enabled are covered in each mode. A reset applied in the middle of a run discards a parity check that is already pending.

// File: rtl/ca_pkg.sv
package ca_pkg;

    localparam int CKE_W   = 2;
    localparam int ODT_W   = 2;
    localparam int CS_W    = 4;
    localparam int CS_HALF = CS_W / 2;

    typedef struct packed {
        logic [CKE_W-1:0] cke;
        logic [ODT_W-1:0] odt;
    } ctrl_t;

    typedef enum logic {
        CS_QUAD = 1'b0,
        CS_DUAL = 1'b1
    } cs_mode_e;

    // Map raw chip selects onto the output pins for the given mode.
    function automatic logic [CS_W-1:0] cs_route(input logic [CS_W-1:0] cs_n,
                                                 input cs_mode_e        mode);
        logic [CS_W-1:0] r;
        if (mode == CS_QUAD) r = cs_n;
        else                 r = {cs_n[CS_HALF-1:0], cs_n[CS_HALF-1:0]};
        return r;
    endfunction

    // True when any chip select enabled in this mode is asserted (low).
    function automatic logic cs_any(input logic [CS_W-1:0] cs_n,
                                    input cs_mode_e        mode);
        logic s;
        if (mode == CS_QUAD) s = ~&cs_n;
        else                 s = ~&cs_n[CS_HALF-1:0];
        return s;
    endfunction

endpackage

// File: rtl/ca_capture.sv
module ca_capture
    import ca_pkg::*;
#(
    parameter int AC_W = 22
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AC_W-1:0] ac_in,
    input  ctrl_t           ctrl_in,
    output logic [AC_W-1:0] ac_a,
    output logic [AC_W-1:0] ac_b,
    output ctrl_t           ctrl_a,
    output ctrl_t           ctrl_b
);

    // Separate flop banks per side, each driving its own load.
    always_ff @(posedge clk) begin
        if (rst) begin
            ac_a   <= '0;
            ctrl_a <= '0;
        end else begin
            ac_a   <= ac_in;
            ctrl_a <= ctrl_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_b   <= '0;
            ctrl_b <= '0;
        end else begin
            ac_b   <= ac_in;
            ctrl_b <= ctrl_in;
        end
    end

    // R1
    capture_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ac_a == $past(ac_in) && ctrl_a == $past(ctrl_in)));

    // R2
    side_match_chk: assert property (@(posedge clk) disable iff (rst)
        (ac_a == ac_b) && (ctrl_a == ctrl_b));

endmodule

// File: rtl/ca_cs_router.sv
module ca_cs_router
    import ca_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  cs_mode_e        mode,
    input  logic [CS_W-1:0] cs_in_n,
    output logic [CS_W-1:0] cs_out_n
);

    always_ff @(posedge clk) begin
        if (rst) cs_out_n <= '1;
        else     cs_out_n <= cs_route(cs_in_n, mode);
    end

    // R3
    dual_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == CS_DUAL) |->
        (cs_out_n[CS_HALF-1:0] == $past(cs_in_n[CS_HALF-1:0]) &&
         cs_out_n[CS_W-1:CS_HALF] == $past(cs_in_n[CS_HALF-1:0])));

    // R4
    quad_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == CS_QUAD) |-> cs_out_n == $past(cs_in_n));

    // R9
    reset_desel_chk: assert property (@(posedge clk)
        rst |=> &cs_out_n);

endmodule

// File: rtl/ca_parity_chk.sv
module ca_parity_chk
    import ca_pkg::*;
#(
    parameter int AC_W     = 22,
    parameter int ERR_HOLD = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  cs_mode_e        mode,
    input  logic [AC_W-1:0] ac_in,
    input  logic [CS_W-1:0] cs_in_n,
    input  logic            par_in,
    output logic            err_n
);

    localparam int CNT_W = $clog2(ERR_HOLD + 1);

    logic             calc_q;
    logic             sel_q;
    logic [CNT_W-1:0] hold_q;
    logic             mismatch;

    // Stage 1: parity of the command and whether it was selected.
    always_ff @(posedge clk) begin
        if (rst) begin
            calc_q <= 1'b0;
            sel_q  <= 1'b0;
        end else begin
            calc_q <= ^ac_in;
            sel_q  <= cs_any(cs_in_n, mode);
        end
    end

    // Stage 2: late parity bit meets the stored result.
    assign mismatch = sel_q & (calc_q ^ par_in);

    always_ff @(posedge clk) begin
        if (rst)                hold_q <= '0;
        else if (mismatch)      hold_q <= CNT_W'(ERR_HOLD);
        else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
    end

    assign err_n = (hold_q == '0);

    // R7
    sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n) |-> $past(sel_q));

    // R5
    mismatch_flag_chk: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> !err_n);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_n) |-> !$past(mismatch));

    generate
        if (ERR_HOLD > 1) begin : g_min_width
            // R8
            min_width_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(err_n) |=> !err_n);
        end
    endgenerate

    // R9
    reset_err_chk: assert property (@(posedge clk)
        rst |=> err_n);

endmodule

// File: rtl/ca_regbuf.sv
module ca_regbuf
    import ca_pkg::*;
#(
    parameter int AC_W     = 22,
    parameter int ERR_HOLD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             quad_cs_n,
    input  logic [AC_W-1:0]  ac_in,
    input  logic [CKE_W-1:0] cke_in,
    input  logic [ODT_W-1:0] odt_in,
    input  logic [CS_W-1:0]  cs_in_n,
    input  logic             par_in,
    output logic [AC_W-1:0]  ac_a,
    output logic [AC_W-1:0]  ac_b,
    output logic [CKE_W-1:0] cke_a,
    output logic [CKE_W-1:0] cke_b,
    output logic [ODT_W-1:0] odt_a,
    output logic [ODT_W-1:0] odt_b,
    output logic [CS_W-1:0]  cs_out_n,
    output logic             err_n
);

    cs_mode_e mode;
    ctrl_t    ctrl_in, ctrl_a, ctrl_b;

    assign mode    = cs_mode_e'(quad_cs_n);
    assign ctrl_in = '{cke: cke_in, odt: odt_in};

    ca_capture #(.AC_W(AC_W)) capture_i (
        .clk     (clk),
        .rst     (rst),
        .ac_in   (ac_in),
        .ctrl_in (ctrl_in),
        .ac_a    (ac_a),
        .ac_b    (ac_b),
        .ctrl_a  (ctrl_a),
        .ctrl_b  (ctrl_b)
    );

    assign cke_a = ctrl_a.cke;
    assign odt_a = ctrl_a.odt;
    assign cke_b = ctrl_b.cke;
    assign odt_b = ctrl_b.odt;

    ca_cs_router router_i (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .cs_in_n  (cs_in_n),
        .cs_out_n (cs_out_n)
    );

    ca_parity_chk #(.AC_W(AC_W), .ERR_HOLD(ERR_HOLD)) parity_i (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .ac_in   (ac_in),
        .cs_in_n (cs_in_n),
        .par_in  (par_in),
        .err_n   (err_n)
    );

    // R9
    reset_ctrl_chk: assert property (@(posedge clk)
        rst |=> (cke_a == '0 && cke_b == '0 && odt_a == '0 && ac_a == '0));

endmodule

// File: tb/ca_regbuf_tb_top.sv
module ca_regbuf_tb_top;

    localparam int AC_W = 22;
    localparam int HOLD = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            quad_cs_n = 1'b1;
    logic [AC_W-1:0] ac_in = '0;
    logic [1:0]      cke_in = '0, odt_in = '0;
    logic [3:0]      cs_in_n = '1;
    logic            par_in = 1'b0;
    logic [AC_W-1:0] ac_a, ac_b;
    logic [1:0]      cke_a, cke_b, odt_a, odt_b;
    logic [3:0]      cs_out_n;
    logic            err_n;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ca_regbuf #(.AC_W(AC_W), .ERR_HOLD(HOLD)) dut_i (
        .clk(clk), .rst(rst), .quad_cs_n(quad_cs_n), .ac_in(ac_in),
        .cke_in(cke_in), .odt_in(odt_in), .cs_in_n(cs_in_n), .par_in(par_in),
        .ac_a(ac_a), .ac_b(ac_b), .cke_a(cke_a), .cke_b(cke_b),
        .odt_a(odt_a), .odt_b(odt_b), .cs_out_n(cs_out_n), .err_n(err_n)
    );

    // Behavioural reference model
    logic [AC_W-1:0] m_ac = '0;
    logic [1:0]      m_cke = '0, m_odt = '0;
    logic [3:0]      m_cs = '1;
    int              m_hold = 0;
    bit [1:0]        pq[$];   // {selected, parity}

    function automatic bit sum_parity(input logic [AC_W-1:0] v);
        int s = 0;
        for (int i = 0; i < AC_W; i++) s += int'(v[i]);
        return bit'(s % 2);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ac = '0; m_cke = '0; m_odt = '0; m_cs = '1; m_hold = 0;
            pq.delete();
        end else begin
            bit [1:0] pe;
            int n_en, lows;
            if (pq.size() > 0) begin
                pe = pq.pop_front();
                if (pe[1] && pe[0] != par_in) m_hold = HOLD;
                else if (m_hold > 0)          m_hold--;
            end else if (m_hold > 0) m_hold--;
            m_ac = ac_in; m_cke = cke_in; m_odt = odt_in;
            for (int i = 0; i < 4; i++)
                m_cs[i] = quad_cs_n ? cs_in_n[i % 2] : cs_in_n[i];
            n_en = quad_cs_n ? 2 : 4;
            lows = 0;
            for (int i = 0; i < n_en; i++) if (!cs_in_n[i]) lows++;
            pq.push_back({bit'(lows > 0), sum_parity(ac_in)});
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1", "ac_a", 64'(ac_a), 64'(m_ac));
        chk("R1", "cke_a", 64'(cke_a), 64'(m_cke));
        chk("R1", "odt_a", 64'(odt_a), 64'(m_odt));
        chk("R2", "ac_b", 64'(ac_b), 64'(m_ac));
        chk("R2", "cke_b", 64'(cke_b), 64'(m_cke));
        chk("R2", "odt_b", 64'(odt_b), 64'(m_odt));
        chk(quad_cs_n ? "R3" : "R4", "cs_out_n", 64'(cs_out_n), 64'(m_cs));
        chk("R5/R8", "err_n", 64'(err_n), 64'(m_hold == 0));
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic random_run(input int n);
        bit good = 0;
        for (int k = 0; k < n; k++) begin
            par_in  = good ^ ($urandom_range(7) == 0);
            ac_in   = AC_W'($urandom);
            cke_in  = 2'($urandom);
            odt_in  = 2'($urandom);
            cs_in_n = 4'($urandom);
            good    = sum_parity(ac_in);
            tick();
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R9 reset state
        chk("R9", "cs_out_n reset", 64'(cs_out_n), 64'hF);
        chk("R9", "cke_a reset", 64'(cke_a), 64'h0);
        chk("R9", "err_n reset", 64'(err_n), 64'h1);
        rst = 1'b0;

        quad_cs_n = 1'b1; random_run(400);   // R3 dual mode
        quad_cs_n = 1'b0; random_run(400);   // R4 quad mode
        quad_cs_n = 1'b1;

        // R7: dual mode, only upper selects low, wrong parity -> no error
        ac_in = AC_W'(3); cs_in_n = 4'b0011; par_in = 1'b0; tick();
        ac_in = '0; cs_in_n = 4'b1111; par_in = 1'b1; tick();
        chk("R7", "unselected err_n", 64'(err_n), 64'h1);
        tick();

        // R6: controls toggled, address-only parity supplied -> no error
        ac_in = AC_W'(1); cke_in = 2'b11; odt_in = 2'b11; cs_in_n = 4'b1110; tick();
        ac_in = '0; cke_in = 2'b00; odt_in = 2'b01; cs_in_n = 4'b1111; par_in = 1'b1; tick();
        chk("R6", "controls excluded err_n", 64'(err_n), 64'h1);
        par_in = 1'b0; tick();

        // R5/R8: selected mismatch -> low exactly HOLD cycles
        ac_in = AC_W'(7); cs_in_n = 4'b1101; tick();
        ac_in = '0; cs_in_n = 4'b1111; par_in = 1'b0; tick();
        chk("R5", "mismatch err_n", 64'(err_n), 64'h0);
        tick();
        chk("R8", "held err_n", 64'(err_n), 64'h0);
        tick();
        chk("R8", "released err_n", 64'(err_n), 64'h1);

        // R8 restart: two consecutive selected mismatches
        ac_in = AC_W'(1); cs_in_n = 4'b1110; par_in = 1'b0; tick();
        ac_in = AC_W'(1); par_in = 1'b0; tick();
        ac_in = '0; cs_in_n = 4'b1111; par_in = 1'b0; tick();
        chk("R8", "restart err_n t1", 64'(err_n), 64'h0);
        tick();
        chk("R8", "restart err_n t2", 64'(err_n), 64'h0);
        tick();
        chk("R8", "restart release", 64'(err_n), 64'h1);

        // R9: reset drops a pending selected check
        ac_in = AC_W'(1); cs_in_n = 4'b0000; cke_in = 2'b11; tick();
        rst = 1'b1; par_in = 1'b0; tick();
        chk("R9", "mid reset cs_out_n", 64'(cs_out_n), 64'hF);
        chk("R9", "mid reset cke_b", 64'(cke_b), 64'h0);
        rst = 1'b0; ac_in = '0; cs_in_n = 4'b1111; tick();
        chk("R9", "pending dropped err_n", 64'(err_n), 64'h1);

        quad_cs_n = 1'b0; random_run(200);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule